// File: doc/BRIEF.md
# Preemptive CAMAC Cycle Arbiter

This block decides which cycle goes out next on one serial CAMAC cable that two request sources share. A time-critical source queues short requests. Each request is a command and a cycle count, and the requests are held in a small first-in first-out queue. A background source submits one block transfer at a time. A transfer has a command, a buffer pointer, a length in 16-bit cycles, an optional setup write (for example an address-pointer load), and two lock flags. The arbiter sends work to a cycle engine one cycle at a time with a start/done handshake. Every cycle end is therefore a decision point.

A pending time-critical cycle takes the cable at the first decision point, unless the background transfer holds a lock. A transfer holds a lock in two cases: it was submitted as non-interruptible, or it is between the two 16-bit halves of a 32-bit word. The background transfer keeps its progress while it is displaced. When it gets the cable back, it first replays its setup write, with the data advanced by the number of words already moved. It then continues at the next word, so no word is repeated or skipped.

Top module: `camac_cycle_arbiter`

## Requirements
- R1: While rst_n is low and on the first clock after it, e_start is 0, u_ready and b_ready are 1, and bg_busy and urg_pending are 0.
- R2: When a cycle ends and time-critical work is queued while lock_hold is 0, the next cycle issued is time-critical (e_urgent=1). A background cycle (e_urgent=0) is issued only when the urgent queue is empty or lock_hold is 1.
- R3: In a transfer submitted with b_pair=1, cycles pair up into 32-bit words. No time-critical cycle is issued after an odd number of the transfer's data cycles.
- R4: A transfer started with b_nolock=1 runs from its first cycle to its last with no time-critical cycle in between.
- R5: A transfer with b_has_setup=1 begins with a setup cycle (e_setup=1, e_cmd=b_setup_cmd). After each interruption of a started transfer, the setup cycle is issued again with e_wdata = b_setup_data + words already done. Setup cycles do not count toward b_count.
- R6: The data cycles of a background transfer present e_addr = b_base, b_base+1, ... b_base+b_count-1, each exactly once and in that order, with e_cmd=b_cmd.
- R7: Time-critical requests are served in arrival order. A request of count k produces k cycles with e_addr 0..k-1 and e_cmd=u_cmd. u_ready is 0 while UQ_DEPTH requests are queued.
- R8: A background transfer submitted while time-critical work is queued issues no cycle until the queue has drained.
- R9: b_ready is 0 while a transfer is active (bg_busy=1). A b_valid in that time is ignored and does not change the running transfer.
- R10: At most one cycle is in flight. e_start is a one-clock pulse, and the next e_start comes no earlier than the clock after e_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| u_valid | input | 1 | Time-critical request offered |
| u_ready | output | 1 | Urgent queue has room |
| u_cmd | input | CW | Command of the time-critical request |
| u_count | input | NW | Cycles in the time-critical request (at least 1) |
| b_valid | input | 1 | Background transfer offered |
| b_ready | output | 1 | No background transfer active |
| b_cmd | input | CW | Command of the data cycles |
| b_base | input | AW | Buffer pointer of the first word |
| b_count | input | NW | Data cycles in the transfer (at least 1) |
| b_has_setup | input | 1 | Transfer starts with a setup write |
| b_setup_cmd | input | CW | Command of the setup write |
| b_setup_data | input | DW | Setup write data at word zero |
| b_pair | input | 1 | Cycles form 32-bit word pairs |
| b_nolock | input | 1 | Whole transfer non-interruptible |
| e_start | output | 1 | Cycle issued to the engine |
| e_urgent | output | 1 | Issued cycle is time-critical |
| e_setup | output | 1 | Issued cycle is a setup write |
| e_cmd | output | CW | Command of the issued cycle |
| e_addr | output | AW | Buffer pointer or request word index |
| e_wdata | output | DW | Setup write data |
| e_done | input | 1 | Engine finished the cycle in flight |
| urg_pending | output | 1 | Urgent queue not empty |
| lock_hold | output | 1 | Background transfer currently refuses preemption |
| bg_busy | output | 1 | Background transfer active |

## Verification
The assertions check, on every clock, that only one cycle is ever in flight. They also check that no time-critical cycle is issued while lock_hold was set, that no background cycle is issued while urgent work was queued without a lock, that setup cycles never carry the urgent flag, and that an accepted transfer always shows as busy. Some behaviours span a whole transfer, and only the bench scenarios can show them. These are the replayed setup data following the word count, the coverage of every buffer word exactly once, the ordering of queued urgent requests behind a non-interruptible transfer, and a background submission waiting for a burst of urgent work to drain. The bench checks these against a behavioural model on every clock.

// File: rtl/camac_cycle_arbiter.sv
module camac_cycle_arbiter #(
  parameter int CW = 16,
  parameter int AW = 16,
  parameter int DW = 24,
  parameter int NW = 8,
  parameter int UQ_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          u_valid,
  output logic          u_ready,
  input  logic [CW-1:0] u_cmd,
  input  logic [NW-1:0] u_count,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [CW-1:0] b_cmd,
  input  logic [AW-1:0] b_base,
  input  logic [NW-1:0] b_count,
  input  logic          b_has_setup,
  input  logic [CW-1:0] b_setup_cmd,
  input  logic [DW-1:0] b_setup_data,
  input  logic          b_pair,
  input  logic          b_nolock,
  output logic          e_start,
  output logic          e_urgent,
  output logic          e_setup,
  output logic [CW-1:0] e_cmd,
  output logic [AW-1:0] e_addr,
  output logic [DW-1:0] e_wdata,
  input  logic          e_done,
  output logic          urg_pending,
  output logic          lock_hold,
  output logic          bg_busy
);
  localparam int PW = (UQ_DEPTH > 1) ? $clog2(UQ_DEPTH) : 1;
  localparam int LW = PW + 1;

  logic [CW-1:0] uq_cmd [UQ_DEPTH];
  logic [NW-1:0] uq_cnt [UQ_DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level;
  logic [NW-1:0] u_idx;

  logic          bg_act, bg_started, need_setup;
  logic          bg_hs, bg_pr, bg_nl;
  logic [CW-1:0] bg_cmd, bg_scmd;
  logic [AW-1:0] bg_base;
  logic [DW-1:0] bg_sdata;
  logic [NW-1:0] bg_cnt, bg_done;
  logic          inflight;

  logic free, go_u, go_b, push, pop;

  assign u_ready     = level < LW'(UQ_DEPTH);
  assign b_ready     = !bg_act;
  assign bg_busy     = bg_act;
  assign urg_pending = level != '0;
  assign lock_hold   = bg_act && bg_started && (bg_nl || (bg_pr && bg_done[0]));
  assign free        = !inflight;
  assign go_u        = free && urg_pending && !lock_hold;
  assign go_b        = free && bg_act && !go_u;
  assign push        = u_valid && u_ready;
  assign pop         = go_u && ((u_idx + 1'b1) >= uq_cnt[rd_ptr]);

  always_ff @(posedge clk) begin
    if (push) begin
      uq_cmd[wr_ptr] <= u_cmd;
      uq_cnt[wr_ptr] <= u_count;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      u_idx  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      level <= level + LW'(push) - LW'(pop);
      if (go_u) u_idx <= pop ? '0 : u_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bg_act     <= 1'b0;
      bg_started <= 1'b0;
      need_setup <= 1'b0;
      bg_hs      <= 1'b0;
      bg_pr      <= 1'b0;
      bg_nl      <= 1'b0;
      bg_cmd     <= '0;
      bg_scmd    <= '0;
      bg_base    <= '0;
      bg_sdata   <= '0;
      bg_cnt     <= '0;
      bg_done    <= '0;
    end else if (!bg_act) begin
      if (b_valid) begin
        bg_act     <= 1'b1;
        bg_started <= 1'b0;
        need_setup <= b_has_setup;
        bg_hs      <= b_has_setup;
        bg_pr      <= b_pair;
        bg_nl      <= b_nolock;
        bg_cmd     <= b_cmd;
        bg_scmd    <= b_setup_cmd;
        bg_base    <= b_base;
        bg_sdata   <= b_setup_data;
        bg_cnt     <= b_count;
        bg_done    <= '0;
      end
    end else if (go_u) begin
      if (bg_started && bg_hs) need_setup <= 1'b1;
    end else if (go_b) begin
      bg_started <= 1'b1;
      if (need_setup) begin
        need_setup <= 1'b0;
      end else begin
        bg_done <= bg_done + 1'b1;
        if ((bg_done + 1'b1) == bg_cnt) bg_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      e_start  <= 1'b0;
      e_urgent <= 1'b0;
      e_setup  <= 1'b0;
      e_cmd    <= '0;
      e_addr   <= '0;
      e_wdata  <= '0;
    end else begin
      e_start <= go_u || go_b;
      if (go_u || go_b)           inflight <= 1'b1;
      else if (inflight && e_done) inflight <= 1'b0;
      if (go_u) begin
        e_urgent <= 1'b1;
        e_setup  <= 1'b0;
        e_cmd    <= uq_cmd[rd_ptr];
        e_addr   <= AW'(u_idx);
        e_wdata  <= '0;
      end else if (go_b) begin
        e_urgent <= 1'b0;
        e_setup  <= need_setup;
        e_cmd    <= need_setup ? bg_scmd : bg_cmd;
        e_addr   <= need_setup ? '0 : bg_base + AW'(bg_done);
        e_wdata  <= need_setup ? bg_sdata + DW'(bg_done) : '0;
      end
    end
  end
endmodule

// File: rtl/camac_cycle_arbiter_chk.sv
module camac_cycle_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic e_start,
  input logic e_urgent,
  input logic e_setup,
  input logic e_done,
  input logic urg_pending,
  input logic lock_hold,
  input logic bg_busy,
  input logic b_valid,
  input logic b_ready
);
  logic ck_busy;
  always_ff @(posedge clk) begin
    if (!rst_n)       ck_busy <= 1'b0;
    else if (e_start) ck_busy <= 1'b1;
    else if (e_done)  ck_busy <= 1'b0;
  end

  a_r10_single_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    e_start |-> !ck_busy);
  a_r2_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    (e_start && !e_urgent) |-> $past(!urg_pending || lock_hold));
  a_r3_respect_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (e_start && e_urgent) |-> $past(!lock_hold));
  a_r5_setup_is_bg: assert property (@(posedge clk) disable iff (!rst_n)
    (e_start && e_setup) |-> (bg_busy && !e_urgent));
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_ready) |=> bg_busy);
endmodule

bind camac_cycle_arbiter camac_cycle_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .e_start(e_start), .e_urgent(e_urgent),
  .e_setup(e_setup), .e_done(e_done), .urg_pending(urg_pending),
  .lock_hold(lock_hold), .bg_busy(bg_busy), .b_valid(b_valid), .b_ready(b_ready)
);

// File: tb/camac_cycle_arbiter_tb.sv
module camac_cycle_arbiter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic u_valid = 0, b_valid = 0, b_has_setup = 0, b_pair = 0, b_nolock = 0, e_done = 0;
  logic [15:0] u_cmd = 0, b_cmd = 0, b_setup_cmd = 0, b_base = 0;
  logic [7:0] u_count = 0, b_count = 0;
  logic [23:0] b_setup_data = 0;
  logic u_ready, b_ready, e_start, e_urgent, e_setup, urg_pending, lock_hold, bg_busy;
  logic [15:0] e_cmd, e_addr;
  logic [23:0] e_wdata;

  camac_cycle_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .u_valid(u_valid), .u_ready(u_ready), .u_cmd(u_cmd),
    .u_count(u_count), .b_valid(b_valid), .b_ready(b_ready), .b_cmd(b_cmd),
    .b_base(b_base), .b_count(b_count), .b_has_setup(b_has_setup),
    .b_setup_cmd(b_setup_cmd), .b_setup_data(b_setup_data), .b_pair(b_pair),
    .b_nolock(b_nolock), .e_start(e_start), .e_urgent(e_urgent), .e_setup(e_setup),
    .e_cmd(e_cmd), .e_addr(e_addr), .e_wdata(e_wdata), .e_done(e_done),
    .urg_pending(urg_pending), .lock_hold(lock_hold), .bg_busy(bg_busy));

  int n_cmp = 0, n_bad = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int mq_cmd[$], mq_cnt[$];
  int m_uidx, m_cmd, m_base, m_cnt, m_done, m_scmd, m_sdata;
  bit m_inf, m_bga, m_bgs, m_need, m_hs, m_pair, m_nl;
  bit x_start, x_urg, x_setup;
  int x_cmd, x_addr, x_wdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq_cmd.delete(); mq_cnt.delete();
      m_uidx = 0; m_inf = 0; m_bga = 0; m_bgs = 0; m_need = 0; x_start = 0;
    end else begin
      bit free, can_push, bg_free, lock;
      free = !m_inf; can_push = mq_cmd.size() < 4; bg_free = !m_bga;
      lock = m_bga && m_bgs && (m_nl || (m_pair && (m_done % 2 == 1)));
      if (m_inf && e_done) m_inf = 0;
      x_start = 0;
      if (free && mq_cmd.size() > 0 && !lock) begin
        x_start = 1; x_urg = 1; x_setup = 0; x_cmd = mq_cmd[0]; x_addr = m_uidx; m_inf = 1;
        if (m_bga && m_bgs && m_hs) m_need = 1;
        m_uidx++;
        if (m_uidx >= mq_cnt[0]) begin
          void'(mq_cmd.pop_front()); void'(mq_cnt.pop_front()); m_uidx = 0;
        end
      end else if (free && m_bga) begin
        x_start = 1; x_urg = 0; m_inf = 1; m_bgs = 1;
        if (m_need) begin
          x_setup = 1; x_cmd = m_scmd; x_addr = 0; x_wdata = (m_sdata + m_done) & 24'hFFFFFF; m_need = 0;
        end else begin
          x_setup = 0; x_cmd = m_cmd; x_addr = (m_base + m_done) & 16'hFFFF;
          m_done++;
          if (m_done == m_cnt) m_bga = 0;
        end
      end
      if (u_valid && can_push) begin mq_cmd.push_back(u_cmd); mq_cnt.push_back(u_count); end
      if (b_valid && bg_free) begin
        m_bga = 1; m_bgs = 0; m_need = b_has_setup; m_hs = b_has_setup; m_pair = b_pair;
        m_nl = b_nolock; m_cmd = b_cmd; m_base = b_base; m_cnt = b_count; m_done = 0;
        m_scmd = b_setup_cmd; m_sdata = b_setup_data;
      end
    end
  end

  // comparison, scenario monitor and cycle engine
  int lat = 2, eng_cnt = 0;
  int u_cyc = 0, s_cyc = 0, b_cyc = 0, words_obs = 0, bg_first_u = 0, nl_viol = 0;
  int cur_base, cur_cnt, cur_sdata;
  bit cur_pair, cur_nl;
  int ulog[$];

  always @(negedge clk) begin
    if (rst_n) begin
      string req; bit ok;
      ok = 1; req = "R2";
      if (e_start !== x_start) ok = 0;
      else if (e_start && (e_urgent !== x_urg || e_cmd !== 16'(x_cmd))) ok = 0;
      else if (e_start && e_setup !== x_setup) begin ok = 0; req = "R5"; end
      else if (e_start && e_setup && e_wdata !== 24'(x_wdata)) begin ok = 0; req = "R5"; end
      else if (e_start && e_addr !== 16'(x_addr)) begin ok = 0; req = "R6"; end
      else if (u_ready !== (mq_cmd.size() < 4) || urg_pending !== (mq_cmd.size() > 0)) begin ok = 0; req = "R7"; end
      else if (b_ready !== !m_bga || bg_busy !== m_bga) begin ok = 0; req = "R9"; end
      check(ok, req, {e_start, e_urgent, e_setup, e_cmd}, {x_start, x_urg, x_setup, x_cmd[15:0]});
      if (e_start) begin
        if (e_urgent) begin
          u_cyc++;
          if (e_addr == 0) ulog.push_back(e_cmd);
          if (bg_busy && cur_pair && words_obs % 2 == 1)
            check(0, "R3", words_obs, words_obs + 1);
          if (cur_nl && words_obs > 0 && words_obs < cur_cnt) nl_viol++;
        end else if (e_setup) begin
          s_cyc++;
          check(e_wdata == 24'(cur_sdata + words_obs), "R5", e_wdata, cur_sdata + words_obs);
        end else begin
          if (words_obs == 0) bg_first_u = u_cyc;
          if (e_addr != 16'(cur_base + words_obs)) check(0, "R6", e_addr, cur_base + words_obs);
          words_obs++; b_cyc++;
        end
      end
    end
    if (e_done) e_done = 0;
    if (e_start) begin
      if (eng_cnt != 0) check(0, "R10", eng_cnt, 0);
      eng_cnt = lat;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) e_done = 1;
    end
  end

  task automatic push_u(input int cmd, input int cnt);
    @(negedge clk);
    while (!u_ready) @(negedge clk);
    u_valid = 1; u_cmd = 16'(cmd); u_count = 8'(cnt);
    @(negedge clk);
    u_valid = 0;
  endtask

  task automatic push_b(input int cmd, input int base, input int cnt, input bit hs,
                        input int sdata, input bit pr, input bit nl);
    @(negedge clk);
    while (!b_ready) @(negedge clk);
    @(negedge clk);
    cur_base = base; cur_cnt = cnt; cur_sdata = sdata; cur_pair = pr; cur_nl = nl; words_obs = 0;
    b_valid = 1; b_cmd = 16'(cmd); b_base = 16'(base); b_count = 8'(cnt); b_has_setup = hs;
    b_setup_cmd = 16'h0910; b_setup_data = 24'(sdata); b_pair = pr; b_nolock = nl;
    @(negedge clk);
    b_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (bg_busy || urg_pending || eng_cnt != 0 || e_start) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int s0, b0, u0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(e_start == 0 && u_ready == 1 && b_ready == 1 && bg_busy == 0 && urg_pending == 0,
          "R1", {e_start, u_ready, b_ready, bg_busy, urg_pending}, 5'b01100);
    rst_n = 1;
    @(negedge clk);
    check(e_start == 0 && b_ready == 1, "R1", {e_start, b_ready}, 2'b01);

    // plain transfer with setup: R5, R6
    lat = 2; s0 = s_cyc; b0 = b_cyc;
    push_b('h0A11, 'h100, 4, 1, 'h500, 0, 0);
    wait_idle();
    check(b_cyc - b0 == 4, "R6", b_cyc - b0, 4);
    check(s_cyc - s0 == 1, "R5", s_cyc - s0, 1);

    // preemption mid transfer, replay then resume: R2, R5, R7
    s0 = s_cyc; b0 = b_cyc; u0 = u_cyc;
    push_b('h0A22, 'h200, 8, 1, 'h2000, 0, 0);
    while (words_obs < 3) @(negedge clk);
    push_u('h1111, 2);
    push_u('h2222, 1);
    wait_idle();
    check(s_cyc - s0 >= 2, "R5", s_cyc - s0, 2);
    check(b_cyc - b0 == 8, "R6", b_cyc - b0, 8);
    check(u_cyc - u0 == 3, "R2", u_cyc - u0, 3);
    check(ulog[ulog.size()-2] == 'h1111 && ulog[ulog.size()-1] == 'h2222, "R7",
          ulog[ulog.size()-2], 'h1111);

    // 32-bit word pairs: R3
    lat = 1; b0 = b_cyc;
    push_b('h0A33, 'h300, 8, 1, 'h40, 1, 0);
    while (words_obs < 1) @(negedge clk);
    push_u('h3333, 1);
    while (words_obs < 5) @(negedge clk);
    push_u('h3334, 2);
    wait_idle();
    check(b_cyc - b0 == 8, "R3", b_cyc - b0, 8);

    // non-interruptible transfer, full queue, ignored submission: R4, R7, R9
    lat = 2; b0 = b_cyc; u0 = u_cyc; nl_viol = 0;
    push_b('h0A44, 'h400, 10, 0, 0, 0, 1);
    while (words_obs < 1) @(negedge clk);
    push_u('h4441, 1);
    push_u('h4442, 1);
    push_u('h4443, 1);
    push_u('h4444, 1);
    check(u_ready == 0, "R7", u_ready, 0);
    b_valid = 1; b_count = 8'd3; b_base = 16'h0777;
    check(b_ready == 0, "R9", b_ready, 0);
    @(negedge clk); @(negedge clk);
    b_valid = 0;
    wait_idle();
    check(nl_viol == 0, "R4", nl_viol, 0);
    check(b_cyc - b0 == 10, "R9", b_cyc - b0, 10);
    check(u_cyc - u0 == 4, "R7", u_cyc - u0, 4);
    check(ulog[ulog.size()-4] == 'h4441 && ulog[ulog.size()-1] == 'h4444, "R7",
          ulog[ulog.size()-1], 'h4444);

    // background submitted behind an urgent burst: R8
    lat = 1; u0 = u_cyc; b0 = b_cyc; s0 = s_cyc;
    push_u('h5551, 2);
    push_u('h5552, 2);
    push_u('h5553, 2);
    push_b('h0A55, 'h500, 3, 0, 0, 0, 0);
    wait_idle();
    check(bg_first_u - u0 == 6, "R8", bg_first_u - u0, 6);
    check(b_cyc - b0 == 3 && s_cyc == s0, "R6", b_cyc - b0, 3);

    summary();
  end
endmodule